// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block keeps an external digitally controlled oscillator at a programmed multiple of a slow reference clock, which is nominally 32768 Hz. The block runs on the oscillator's own clock. It divides that clock by D×(N+1) with a free-running counter. It also brings the reference clock in through a synchronizer and finds its rising edges.

Each reference period forms one measurement window. At the end of the window, the block looks at how many divider wrap pulses fell inside it. No pulse means the oscillator is too slow, one pulse means the rate is correct, and two or more mean it is too fast. The result moves a 10-bit saturating control word up by one, down by one, or not at all. The upper five bits of that word drive the oscillator's coarse tap select, and the lower five bits drive its fine modulation input.

Software uses a small write-only register port to set the multiplier, the loop divider and the enables. It can also load the control word directly. With the loop switched off, a loaded value stays fixed. A lock flag reports when the measurement has agreed with the target for several periods in a row.

Top module: `fll_ctrl`

## Requirements
- R1: After reset, tap_code is 16, mod_code is 0 and locked is 0, because the control word resets to 512. The loop and the modulator are both enabled at reset, N resets to 31 and the divider code resets to 0.
- R2: A write to address 0 sets N from wr_data[6:0], and a written 0 is stored as 1. A write to address 1 sets the divider code from wr_data[1:0], where codes 0, 1, 2 and 3 select D = 1, 2, 4 and 8. The oscillator clock is divided by D×(N+1).
- R3: Each rising reference edge closes a window and updates the control word at most once. If the window held no divider pulse, the word rises by 1. If it held exactly one pulse, the word holds. If it held two or more pulses, the word falls by 1.
- R4: The control word saturates at 0 and at 1023 and never wraps.
- R5: tap_code is bits 9:5 of the control word and mod_code is bits 4:0. Address 2 bit 1 is the modulator enable, and while it is 0, mod_code reads 0.
- R6: Address 2 bit 0 is the loop enable. While it is 0, reference edges do not change the control word and locked stays 0.
- R7: A write to address 3 loads wr_data[9:0] into the control word, which is visible on the next cycle.
- R8: locked rises after 4 consecutive hold results and falls on any up or down result.
- R9: A write to N or to the divider code clears locked and leaves the control word unchanged. It also restarts the divider and the window count. The first reference edge after such a write only opens a window and does not evaluate it.
- R10: With an oscillator whose frequency rises with the control word, the closed loop settles to the tap that matches D×(N+1) times the reference frequency, and locked asserts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; every register in the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 N, 1 divider code, 2 control, 3 word load |
| wr_data | input | 10 | Write data |
| tap_code | output | 5 | Coarse tap select to the oscillator |
| mod_code | output | 5 | Fine modulation code to the oscillator |
| locked | output | 1 | Loop is in lock |

## Verification
The assertions assume that the reference clock is much slower than the oscillator clock, with each high and low phase lasting at least two clk cycles. They also assume that wr_addr is only meaningful while wr_en is high. Under those conditions, the control word can change only by a single step, by a load, or not at all.

The exact-value tests change the reference clock on falling edges of the oscillator and space its rising edges by whole numbers of cycles. This makes every window an exact cycle count, so pulse counts in the windows are fixed and known in advance. The closed-loop test drives the reference on its own timebase, asynchronous to the oscillator, and checks only where the loop settles and that lock appears.

// File: rtl/fll_ctrl.sv
module fll_ctrl #(
  parameter int TAP_W    = 5,
  parameter int MOD_W    = 5,
  parameter int NW       = 7,
  parameter int DW       = 2,
  parameter int LOCK_N   = 4,
  parameter int WORD_RST = 512,
  parameter int N_RST    = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_clk,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [TAP_W+MOD_W-1:0]   wr_data,
  output logic [TAP_W-1:0]         tap_code,
  output logic [MOD_W-1:0]         mod_code,
  output logic                     locked
);
  localparam int IW = TAP_W + MOD_W;
  localparam int RW = NW + 1 + (2**DW - 1);
  localparam int LW = $clog2(LOCK_N + 1);
  localparam logic [IW-1:0] WMAX = {IW{1'b1}};

  logic [NW-1:0] n_reg;
  logic [DW-1:0] d_sel;
  logic          loop_en, mod_en;
  logic [IW-1:0] integ;
  logic [RW-1:0] ratio, div_last, div_cnt;
  logic [2:0]    ref_s;
  logic [1:0]    pcnt;
  logic          armed;
  logic [LW-1:0] run;

  wire cfg_wr   = wr_en && !wr_addr[1];
  wire load_wr  = wr_en && (wr_addr == 2'd3);
  wire ref_edge = ref_s[1] && !ref_s[2];
  wire eval     = ref_edge && armed && !cfg_wr;
  wire go_up    = eval && (pcnt == 2'd0);
  wire go_dn    = eval && pcnt[1];
  wire hold     = eval && (pcnt == 2'd1);

  assign ratio     = ({{(RW-NW){1'b0}}, n_reg} + RW'(1)) << d_sel;
  assign div_last  = ratio - RW'(1);
  wire   div_pulse = (div_cnt == div_last);

  assign tap_code = integ[IW-1:MOD_W];
  assign mod_code = mod_en ? integ[MOD_W-1:0] : '0;
  assign locked   = (run == LW'(LOCK_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_reg   <= NW'(N_RST);
      d_sel   <= '0;
      loop_en <= 1'b1;
      mod_en  <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: n_reg <= (wr_data[NW-1:0] == '0) ? NW'(1) : wr_data[NW-1:0];
        2'd1: d_sel <= wr_data[DW-1:0];
        2'd2: {mod_en, loop_en} <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_s <= '0;
    else        ref_s <= {ref_s[1:0], ref_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_cnt <= '0;
    else if (cfg_wr || div_pulse) div_cnt <= '0;
    else                          div_cnt <= div_cnt + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= '0;
      armed <= 1'b0;
    end else if (cfg_wr) begin
      pcnt  <= '0;
      armed <= 1'b0;
    end else if (ref_edge) begin
      pcnt  <= {1'b0, div_pulse};
      armed <= 1'b1;
    end else if (div_pulse && pcnt != 2'd3) begin
      pcnt  <= pcnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             integ <= IW'(WORD_RST);
    else if (load_wr)                       integ <= wr_data;
    else if (loop_en && go_up && integ != WMAX) integ <= integ + IW'(1);
    else if (loop_en && go_dn && integ != '0)   integ <= integ - IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run <= '0;
    else if (cfg_wr || !loop_en)         run <= '0;
    else if (go_up || go_dn)             run <= '0;
    else if (hold && run != LW'(LOCK_N)) run <= run + LW'(1);
  end
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk #(
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [IW-1:0] integ,
  input logic          loop_en,
  input logic          locked
);
  wire ovr = wr_en && (wr_addr == 2'd3);

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |=> (integ == $past(integ) || integ == $past(integ) + IW'(1) || integ + IW'(1) == $past(integ))); // R3

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (integ == {IW{1'b1}} && !ovr) |=> integ != '0); // R4

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (integ == '0 && !ovr) |=> integ != {IW{1'b1}}); // R4

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !ovr) |=> $stable(integ)); // R6

  AST_NO_LOCK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> !locked); // R6

  AST_CFG_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[1]) |=> !locked); // R9
endmodule

bind fll_ctrl fll_ctrl_chk #(.IW(TAP_W + MOD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .integ(integ), .loop_en(loop_en), .locked(locked)
);

// File: tb/fll_ctrl_tb_top.sv
`timescale 1ns/1ps
module fll_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [4:0] tap_code, mod_code;
  logic       locked;

  fll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .tap_code(tap_code), .mod_code(mod_code), .locked(locked)
  );

  // oscillator model, nominal 100 MHz at tap 16; taps 28..31 share one rate
  int unsigned k = 0;
  initial begin
    forever begin
      int ta;
      real half;
      ta = int'(tap_code) + ((k < int'(mod_code)) ? 1 : 0);
      if (ta > 28) ta = 28;
      half = 500.0 / (36.0 + 4.0 * ta);
      #(half) clk = 1'b1;
      #(half) clk = 1'b0;
      k = (k + 1) % 32;
    end
  end

  typedef struct { string tag; int sel; int lo; int hi; longint due; } exp_t;
  exp_t   q[$];
  longint cyc = 0;
  int     n_chk = 0, n_fail = 0;
  bit     seen_lock = 1'b0, watch_lock = 1'b0;

  task automatic check(string tag, string what, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", tag, what, act, lo, hi);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (watch_lock && locked) seen_lock = 1'b1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t it;
        int obs;
        it = q.pop_front();
        case (it.sel)
          0: obs = int'(tap_code);
          1: obs = int'(mod_code);
          2: obs = int'(locked);
          default: obs = int'({tap_code, mod_code});
        endcase
        check(it.tag, (it.sel == 0) ? "tap" : (it.sel == 1) ? "mod" : (it.sel == 2) ? "locked" : "word",
              obs, it.lo, it.hi);
      end
    end
  end

  task automatic expect_rng(string tag, int sel, int lo, int hi);
    exp_t it;
    it.tag = tag; it.sel = sel; it.lo = lo; it.hi = hi; it.due = cyc + 6;
    q.push_back(it);
  endtask

  task automatic expect_eq(string tag, int sel, int v);
    expect_rng(tag, sel, v, v);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ref_edges(int n, int spacing);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_clk = 1'b1;
      repeat (spacing / 2) @(negedge clk);
      ref_clk = 1'b0;
      repeat (spacing - spacing / 2 - 1) @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    expect_eq("R1", 0, 16); expect_eq("R1", 1, 0); expect_eq("R1", 2, 0);
    drain();

    wr(3, 341);                                   // R7 load, R5 split
    expect_eq("R7", 3, 341); expect_eq("R5", 0, 10); expect_eq("R5", 1, 21);
    drain();
    wr(2, 1); expect_eq("R5", 1, 0); expect_eq("R5", 0, 10); drain();
    wr(2, 3); expect_eq("R5", 1, 21); drain();

    wr(0, 127); wr(1, 3);                         // R3 up: divide by 1024
    ref_edges(21, 20);
    expect_eq("R3", 3, 361); expect_eq("R8", 2, 0); drain();

    wr(0, 1); wr(1, 0);                           // R3 down: divide by 2
    ref_edges(21, 20);
    expect_eq("R3", 3, 341); drain();

    wr(0, 31); wr(1, 0);                          // R3 hold, R8 lock timing
    ref_edges(4, 32);
    expect_eq("R8", 2, 0); expect_eq("R3", 3, 341); drain();
    ref_edges(1, 32);
    expect_eq("R8", 2, 1); drain();

    wr(0, 31);                                    // R9
    expect_eq("R9", 2, 0); expect_eq("R9", 3, 341); drain();

    wr(0, 15); wr(1, 1); ref_edges(5, 32);        // R2: D=2, N=15
    expect_eq("R2", 2, 1); expect_eq("R2", 3, 341); drain();
    wr(0, 3); wr(1, 3); ref_edges(5, 32);         // R2: D=8, N=3
    expect_eq("R2", 2, 1); expect_eq("R2", 3, 341); drain();
    wr(0, 0); wr(1, 0); ref_edges(5, 2);          // R2: N=0 stored as 1
    expect_eq("R2", 2, 1); expect_eq("R2", 3, 341); drain();

    wr(2, 2'b10);                                 // R6
    wr(0, 1); wr(1, 0); ref_edges(21, 20);
    expect_eq("R6", 3, 341); expect_eq("R6", 2, 0); drain();

    wr(3, 1020); wr(2, 3); wr(0, 127); wr(1, 3);  // R4 top
    ref_edges(11, 20);
    expect_eq("R4", 3, 1023); drain();
    wr(3, 3); wr(0, 1); wr(1, 0);                 // R4 bottom
    ref_edges(11, 20);
    expect_eq("R4", 3, 0); drain();

    wr(0, 31); wr(1, 0); wr(3, 416);              // R10: target 80 MHz = tap 11
    for (int i = 0; i < 1000; i++) begin
      if (i == 800) watch_lock = 1'b1;
      ref_clk = 1'b1; #200;
      ref_clk = 1'b0; #200;
    end
    watch_lock = 1'b0;
    expect_rng("R10", 0, 10, 12); drain();
    check("R10", "lock seen", int'(seen_lock), 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule